// File: doc/BRIEF.md
# Receive Interrupt Coalescing Controller

This block sits on the receive side of a network controller and decides, frame by frame, whether a good frame gets its own interrupt or is folded into a DMA burst that ends with one completion interrupt. It watches the end-of-frame strobe and the status flags that come with it. A 0.1 µs tick drives an interframe timer. When coalescing is allowed by the configuration, the block withholds the first good frame's interrupt. If a second good frame follows inside the back-to-back window, the block switches into receive DMA mode and gathers frames until eight have been taken or the traffic pauses.

While DMA mode is active, the block asks for transfers with a request line and counts finished transfers on the falling edge of the DMA busy flag. It records the frames of the current burst in a frame count and holds one pending event report for each frame it took. Frames that arrive while the DMA channel is still busy, or after the burst has closed, are missed. They go into a saturating counter and leave no event report behind. The host leaves DMA mode through a handshake: it acknowledges every pending event, reads the frame count until it reads zero, and waits for the transfer in flight to finish.

Top module: `rxcoal_ctrl`

## Requirements
- R1: Coalescing is active only when all of the following hold: cfg_coal_en is 1, at least one of cfg_auto_dma and cfg_dma_only is 1, cfg_good_accept and cfg_good_irq_en are both 1, and cfg_dest_irq_en and cfg_early128_irq_en are both 0. When it is inactive, each qualifying frame pulses irq_rx_ok one cycle after its end-of-frame edge and dma_mode stays 0.
- R2: A frame qualifies only if eof is 1 with addr_ok, len_ok and crc_ok all 1 and cfg_good_accept set. Any other frame raises no interrupt, starts no hold and does not restart the timer.
- R3: With coalescing active, the first qualifying frame raises no interrupt. If the next qualifying frame arrives with a gap of 96 to 520 ticks inclusive, dma_mode is 1 on the following cycle and frame_cnt is 2. The gap is the number of tick pulses counted from the clock after one qualifying end-of-frame up to, but not including, the next.
- R4: If no second qualifying frame arrives and the gap grows past 520 ticks, the withheld frame is released as one irq_rx_ok pulse and dma_mode stays 0.
- R5: If the second qualifying frame arrives with a gap below 96 ticks, the withheld frame is released as one irq_rx_ok pulse and the new frame is withheld in its place.
- R6: In a burst, each qualifying frame taken while dma_busy is 0 adds one to frame_cnt. When frame_cnt reaches 8, the burst closes and irq_dma_done pulses once. irq_rx_ok and irq_dma_done never pulse together.
- R7: A burst whose gap grows past 520 ticks closes with one irq_dma_done pulse and keeps its frame_cnt.
- R8: A qualifying frame that arrives during a burst while dma_busy is 1, or after the burst has closed but before DMA mode ends, is missed. miss_cnt goes up by one, while frame_cnt and evt_pending stay unchanged.
- R9: miss_cnt saturates at its all-ones value. A miss_rd pulse clears it to 0, or to 1 if a miss happens in the same cycle.
- R10: evt_pending goes up by one for each frame taken into a burst, with the first two frames both counted on entry. Each evt_ack lowers it by one, and an evt_ack at 0 is ignored.
- R11: dma_req is 1 while dma_mode is 1, at least one taken frame is still waiting for transfer, and dma_busy is 0. Each fall of dma_busy retires one waiting frame.
- R12: dma_mode drops only after the burst has closed, evt_pending is 0, a cnt_rd has been seen while frame_cnt was 0, dma_busy is 0 and no frame is still waiting. A cnt_rd after the burst has closed clears frame_cnt.
- R13: The interframe timer advances only on cycles where tick is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | 0.1 µs time-base strobe |
| eof | input | 1 | End-of-frame strobe, one cycle |
| addr_ok | input | 1 | Frame passed the destination address filter |
| len_ok | input | 1 | Frame length is legal |
| crc_ok | input | 1 | Frame CRC is valid |
| cfg_coal_en | input | 1 | Coalescing enable |
| cfg_auto_dma | input | 1 | Automatic switch to receive DMA allowed |
| cfg_dma_only | input | 1 | Receive path works in DMA-only mode |
| cfg_good_accept | input | 1 | Good frames are accepted |
| cfg_good_irq_en | input | 1 | Good-frame interrupt enable |
| cfg_dest_irq_en | input | 1 | Early destination-address interrupt enable |
| cfg_early128_irq_en | input | 1 | Early 128-byte interrupt enable |
| dma_busy | input | 1 | DMA channel is moving a frame |
| evt_ack | input | 1 | Host acknowledges one pending event report |
| cnt_rd | input | 1 | Host reads frame_cnt |
| miss_rd | input | 1 | Host reads miss_cnt (clears it) |
| dma_mode | output | 1 | Receive DMA mode active |
| dma_req | output | 1 | Transfer request for a waiting frame |
| frame_cnt | output | $clog2(MAX_BURST+1) | Frames taken in the current burst |
| evt_pending | output | $clog2(MAX_BURST+1) | Event reports not yet acknowledged |
| miss_cnt | output | MISS_W | Saturating missed-frame count |
| irq_rx_ok | output | 1 | Single-frame good-receive interrupt pulse |
| irq_dma_done | output | 1 | Burst-complete interrupt pulse |

## Verification
The hardest case to reach from the ports is the exit handshake in its partial orders, such as a zero read that arrives while event reports are still pending, or a miss in a burst whose earlier transfers have already drained. The stimulus reaches these states with a busy flag that the bench can force independently of its DMA model, and with acknowledgements and zero reads issued in deliberately wrong orders. Window boundaries are hit with exact frame spacings of 96 and 520 ticks. Random bursts vary the first gap and the burst length up to ten frames, so that over-length bursts produce misses after the close.

// File: rtl/rxcoal_pkg.sv
// Shared types for the receive coalescing controller.
package rxcoal_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,  // no frame held
        ST_HOLD  = 2'd1,  // one good frame held, interrupt withheld
        ST_BURST = 2'd2,  // DMA mode, gathering frames
        ST_DRAIN = 2'd3   // burst closed, waiting for host exit handshake
    } coal_state_e;
endpackage

// File: rtl/rxcoal_gap_timer.sv
// Interframe gap timer.
// Counts tick pulses since the last qualifying end-of-frame and saturates one
// past the upper window bound. Assumes GAP_MIN > 0 and GAP_MIN <= GAP_MAX.
// Comes out of reset in the expired state, so no window is open before the first frame.
module rxcoal_gap_timer #(
    parameter int GAP_MIN = 96,
    parameter int GAP_MAX = 520
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic restart,
    output logic in_window,
    output logic expired
);
    localparam int LIMIT = GAP_MAX + 1;
    localparam int GW    = $clog2(LIMIT + 1);

    logic [GW-1:0] gap;

    // Restart on a qualifying frame, otherwise count ticks up to the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            gap <= GW'(LIMIT);
        else if (restart)
            gap <= '0;
        else if (tick && gap != GW'(LIMIT))
            gap <= gap + 1'b1;
    end

    assign in_window = (gap >= GW'(GAP_MIN)) && (gap <= GW'(GAP_MAX));
    assign expired   = (gap == GW'(LIMIT));

    // R13
    gap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !restart) |=> $stable(gap));
    // R4
    gap_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!expired && !in_window));
endmodule

// File: rtl/rxcoal_miss_ctr.sv
// Missed-frame counter.
// Saturates at all ones. A host read clears it, and a miss in the same cycle
// as the read leaves it at 1.
module rxcoal_miss_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    // Clear on read, else count misses without wrapping.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= inc ? W'(1) : '0;
        else if (inc && cnt != MAXV)
            cnt <= cnt + 1'b1;
    end

    // R9
    miss_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> cnt >= $past(cnt));
    // R9
    miss_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == MAXV && !clr) |=> cnt == MAXV);
endmodule

// File: rtl/rxcoal_evt_track.sv
// Pending event report tracker.
// Adds 0..2 reports per cycle for frames taken into a burst and removes one per
// host acknowledge. An acknowledge while nothing is pending is dropped.
module rxcoal_evt_track #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   add,
    input  logic         ack,
    output logic [W-1:0] pending
);
    logic dec;

    // Acknowledge takes effect only if a report is pending.
    always_comb dec = ack && (pending != '0);

    // Update the pending report count.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pending <= '0;
        else
            pending <= pending + W'(add) - W'(dec);
    end

    // R10
    evt_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && pending == '0 && add == 2'd0) |=> pending == '0);
    // R10
    evt_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (add == 2'd0 && !ack) |=> $stable(pending));
endmodule

// File: rtl/rxcoal_ctrl.sv
// Receive interrupt coalescing controller (top).
// Withholds the first good frame's interrupt, enters receive DMA mode when a
// second good frame follows within the back-to-back window, gathers up to
// MAX_BURST frames and raises one completion interrupt. DMA mode is left only
// through the host handshake. Assumes MAX_BURST >= 3 and at most one eof per cycle.
module rxcoal_ctrl
    import rxcoal_pkg::*;
#(
    parameter int GAP_MIN   = 96,
    parameter int GAP_MAX   = 520,
    parameter int MAX_BURST = 8,
    parameter int MISS_W    = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           tick,
    input  logic                           eof,
    input  logic                           addr_ok,
    input  logic                           len_ok,
    input  logic                           crc_ok,
    input  logic                           cfg_coal_en,
    input  logic                           cfg_auto_dma,
    input  logic                           cfg_dma_only,
    input  logic                           cfg_good_accept,
    input  logic                           cfg_good_irq_en,
    input  logic                           cfg_dest_irq_en,
    input  logic                           cfg_early128_irq_en,
    input  logic                           dma_busy,
    input  logic                           evt_ack,
    input  logic                           cnt_rd,
    input  logic                           miss_rd,
    output logic                           dma_mode,
    output logic                           dma_req,
    output logic [$clog2(MAX_BURST+1)-1:0] frame_cnt,
    output logic [$clog2(MAX_BURST+1)-1:0] evt_pending,
    output logic [MISS_W-1:0]              miss_cnt,
    output logic                           irq_rx_ok,
    output logic                           irq_dma_done
);
    localparam int FW = $clog2(MAX_BURST + 1);

    coal_state_e    st;
    logic [FW-1:0]  fcnt;
    logic [FW-1:0]  queue;
    logic           zread;
    logic           busy_q;
    logic           coal_act, qual, in_window, expired;
    logic           start, take, miss, q_dec, can_exit;
    logic [1:0]     add_n;

    // Decode configuration legality and frame qualification.
    always_comb begin
        coal_act = cfg_coal_en && (cfg_auto_dma || cfg_dma_only) && cfg_good_accept
                   && cfg_good_irq_en && !cfg_dest_irq_en && !cfg_early128_irq_en;
        qual     = eof && addr_ok && len_ok && crc_ok && cfg_good_accept;
    end

    // Per-cycle frame disposition and exit condition.
    always_comb begin
        start    = qual && (st == ST_HOLD) && coal_act && in_window;
        take     = qual && (st == ST_BURST) && !dma_busy;
        miss     = qual && (((st == ST_BURST) && dma_busy) || (st == ST_DRAIN));
        add_n    = start ? 2'd2 : (take ? 2'd1 : 2'd0);
        q_dec    = busy_q && !dma_busy && (queue != '0);
        can_exit = (st == ST_DRAIN) && zread && (evt_pending == '0)
                   && !dma_busy && (queue == '0);
    end

    rxcoal_gap_timer #(.GAP_MIN(GAP_MIN), .GAP_MAX(GAP_MAX)) u_gap (
        .clk(clk), .rst_n(rst_n), .tick(tick), .restart(qual),
        .in_window(in_window), .expired(expired)
    );

    rxcoal_miss_ctr #(.W(MISS_W)) u_miss (
        .clk(clk), .rst_n(rst_n), .inc(miss), .clr(miss_rd), .cnt(miss_cnt)
    );

    rxcoal_evt_track #(.W(FW)) u_evt (
        .clk(clk), .rst_n(rst_n), .add(add_n), .ack(evt_ack), .pending(evt_pending)
    );

    // Coalescing state machine with registered interrupt pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st           <= ST_IDLE;
            fcnt         <= '0;
            zread        <= 1'b0;
            irq_rx_ok    <= 1'b0;
            irq_dma_done <= 1'b0;
        end else begin
            irq_rx_ok    <= 1'b0;
            irq_dma_done <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (qual) begin
                        if (coal_act) st <= ST_HOLD;
                        else          irq_rx_ok <= cfg_good_irq_en;
                    end
                end
                ST_HOLD: begin
                    if (!coal_act) begin
                        st        <= ST_IDLE;
                        irq_rx_ok <= 1'b1;
                    end else if (start) begin
                        st   <= ST_BURST;
                        fcnt <= FW'(2);
                    end else if (qual) begin
                        irq_rx_ok <= 1'b1;
                    end else if (expired) begin
                        st        <= ST_IDLE;
                        irq_rx_ok <= 1'b1;
                    end
                end
                ST_BURST: begin
                    if (take) begin
                        fcnt <= fcnt + 1'b1;
                        if (int'(fcnt) + 1 == MAX_BURST) begin
                            st           <= ST_DRAIN;
                            irq_dma_done <= 1'b1;
                        end
                    end else if (expired) begin
                        st           <= ST_DRAIN;
                        irq_dma_done <= 1'b1;
                    end
                end
                ST_DRAIN: begin
                    if (cnt_rd) begin
                        fcnt <= '0;
                        if (fcnt == '0) zread <= 1'b1;
                    end
                    if (can_exit) begin
                        st    <= ST_IDLE;
                        zread <= 1'b0;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Track frames waiting for transfer; retire one per falling busy edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            queue  <= '0;
            busy_q <= 1'b0;
        end else begin
            queue  <= queue + FW'(add_n) - FW'(q_dec);
            busy_q <= dma_busy;
        end
    end

    assign dma_mode  = (st == ST_BURST) || (st == ST_DRAIN);
    assign dma_req   = dma_mode && (queue != '0) && !dma_busy;
    assign frame_cnt = fcnt;

    // R3
    dma_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_mode) |-> ($past(st) == ST_HOLD && $past(in_window)));
    // R12
    dma_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dma_mode) |-> ($past(evt_pending) == '0 && !$past(dma_busy) && $past(zread)));
    // R6
    burst_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(frame_cnt) <= MAX_BURST);
    // R6
    irq_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({irq_rx_ok, irq_dma_done}));
    // R8
    miss_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (miss && !evt_ack) |=> evt_pending == $past(evt_pending));
    // R11
    queue_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(queue) <= MAX_BURST);
endmodule

// File: tb/rxcoal_ctrl_test.sv
module rxcoal_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int WMAX = 520;
    localparam int WMIN = 96;
    localparam int MISS_MAX = 7;

    logic clk = 0, rst_n = 0, tick = 1, eof = 0, addr_ok = 0, len_ok = 0, crc_ok = 0;
    logic cfg_coal_en = 0, cfg_auto_dma = 0, cfg_dma_only = 0, cfg_good_accept = 0;
    logic cfg_good_irq_en = 0, cfg_dest_irq_en = 0, cfg_early128_irq_en = 0;
    logic model_busy = 0, force_busy = 0, dma_busy;
    logic evt_ack = 0, cnt_rd = 0, miss_rd = 0;
    logic dma_mode, dma_req, irq_rx_ok, irq_dma_done;
    logic [3:0] frame_cnt, evt_pending;
    logic [2:0] miss_cnt;

    int n_chk = 0, n_err = 0, rx_irqs = 0, done_irqs = 0;
    bit model_en = 1;
    bit finished = 0;

    assign dma_busy = model_busy | force_busy;

    always #(CLK_PERIOD/2) clk = ~clk;

    rxcoal_ctrl #(.MISS_W(3)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .eof(eof), .addr_ok(addr_ok),
        .len_ok(len_ok), .crc_ok(crc_ok), .cfg_coal_en(cfg_coal_en),
        .cfg_auto_dma(cfg_auto_dma), .cfg_dma_only(cfg_dma_only),
        .cfg_good_accept(cfg_good_accept), .cfg_good_irq_en(cfg_good_irq_en),
        .cfg_dest_irq_en(cfg_dest_irq_en), .cfg_early128_irq_en(cfg_early128_irq_en),
        .dma_busy(dma_busy), .evt_ack(evt_ack), .cnt_rd(cnt_rd), .miss_rd(miss_rd),
        .dma_mode(dma_mode), .dma_req(dma_req), .frame_cnt(frame_cnt),
        .evt_pending(evt_pending), .miss_cnt(miss_cnt), .irq_rx_ok(irq_rx_ok),
        .irq_dma_done(irq_dma_done)
    );

    // Interrupt pulse monitors.
    always @(posedge clk) begin
        if (irq_rx_ok)    rx_irqs++;
        if (irq_dma_done) done_irqs++;
    end

    // DMA channel model: serves a request with a 3-cycle busy period.
    initial begin
        int bcnt = 0;
        forever begin
            @(negedge clk);
            if (bcnt > 0) begin
                bcnt--;
                if (bcnt == 0) model_busy = 0;
            end else if (model_en && dma_req) begin
                model_busy = 1;
                bcnt = 3;
            end
        end
    end

    function automatic bit in_win(int gap);
        return gap >= WMIN && gap <= WMAX;
    endfunction
    function automatic int exp_taken(int len);
        return len > 8 ? 8 : len;
    endfunction
    function automatic int exp_miss(int base, int len);
        int m = base + (len > 8 ? len - 8 : 0);
        return m > MISS_MAX ? MISS_MAX : m;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(bit a, bit l, bit c);
        @(negedge clk);
        eof = 1; addr_ok = a; len_ok = l; crc_ok = c;
        @(negedge clk);
        eof = 0;
    endtask

    // Next good frame's eof edge lands 'spacing' clocks after the previous one.
    task automatic send_after(int spacing);
        idle(spacing - 2);
        send(1, 1, 1);
    endtask

    task automatic ack();
        @(negedge clk); evt_ack = 1; @(negedge clk); evt_ack = 0;
    endtask
    task automatic rd_cnt();
        @(negedge clk); cnt_rd = 1; @(negedge clk); cnt_rd = 0;
    endtask
    task automatic rd_miss();
        @(negedge clk); miss_rd = 1; @(negedge clk); miss_rd = 0;
    endtask

    task automatic cfg_on();
        cfg_coal_en = 1; cfg_auto_dma = 1; cfg_dma_only = 0; cfg_good_accept = 1;
        cfg_good_irq_en = 1; cfg_dest_irq_en = 0; cfg_early128_irq_en = 0;
    endtask

    // Host exit handshake after a closed burst of n frames.
    task automatic finish_cycle(int n);
        chk("R6/R7 frame_cnt at close", frame_cnt, n);
        chk("R10 evt_pending at close", evt_pending, n);
        repeat (n + 1) ack();
        chk("R10 evt_pending after acks (extra ack ignored)", evt_pending, 0);
        chk("R12 dma_mode held before zero read", dma_mode, 1);
        rd_cnt();
        chk("R12 frame_cnt cleared by read", frame_cnt, 0);
        chk("R12 dma_mode held after nonzero read", dma_mode, 1);
        rd_cnt();
        idle(1);
        chk("R12 dma_mode dropped after zero read", dma_mode, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        n_err++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        if (!finished) $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        int base_rx, base_done, base_miss;
        void'($urandom(32'h1234_5678));
        idle(3);
        rst_n = 1;
        idle(1);
        // Reset state
        chk("reset dma_mode", dma_mode, 0);
        chk("reset dma_req", dma_req, 0);
        chk("reset frame_cnt", frame_cnt, 0);
        chk("reset miss_cnt", miss_cnt, 0);
        chk("reset evt_pending", evt_pending, 0);

        // R1: illegal configurations behave as plain per-frame interrupts.
        for (int v = 0; v < 4; v++) begin
            cfg_on();
            case (v)
                0: cfg_coal_en = 0;
                1: cfg_dest_irq_en = 1;
                2: cfg_early128_irq_en = 1;
                default: cfg_auto_dma = 0;
            endcase
            base_rx = rx_irqs;
            send(1, 1, 1);
            send_after(120);
            idle(2);
            chk("R1 per-frame irqs when inactive", rx_irqs - base_rx, 2);
            chk("R1 no dma_mode when inactive", dma_mode, 0);
        end

        // R1: DMA-only mode alone also enables coalescing.
        cfg_on(); cfg_auto_dma = 0; cfg_dma_only = 1;
        base_rx = rx_irqs;
        send(1, 1, 1);
        idle(2);
        chk("R3 first frame withheld", rx_irqs - base_rx, 0);
        send_after(120);
        chk("R1 dma_only burst entry", dma_mode, 1);
        idle(WMAX + 10);
        finish_cycle(2);

        // R2: bad frames are ignored even with coalescing active.
        cfg_on();
        base_rx = rx_irqs;
        send(1, 1, 0); send(0, 1, 1); send(1, 0, 1);
        idle(WMAX + 10);
        chk("R2 no irq for bad frames", rx_irqs - base_rx, 0);
        chk("R2 no dma_mode for bad frames", dma_mode, 0);
        cfg_good_accept = 0;
        send(1, 1, 1);
        idle(WMAX + 10);
        chk("R2 no irq when accept off", rx_irqs - base_rx, 0);
        cfg_on();

        // R4: single frame released after window expiry.
        base_rx = rx_irqs;
        send(1, 1, 1);
        idle(WMAX - 20);
        chk("R4 still withheld inside window", rx_irqs - base_rx, 0);
        idle(40);
        chk("R4 released after expiry", rx_irqs - base_rx, 1);
        chk("R4 dma_mode stays 0", dma_mode, 0);

        // R5: too close (gap 95) releases first, holds second.
        base_rx = rx_irqs;
        send(1, 1, 1);
        send_after(WMIN);
        idle(2);
        chk("R5 first released on close frame", rx_irqs - base_rx, 1);
        chk("R5 no dma_mode", dma_mode, 0);
        idle(WMAX + 10);
        chk("R5 second released later", rx_irqs - base_rx, 2);

        // R3: lower window edge (gap 96) and R7 close by expiry.
        base_rx = rx_irqs; base_done = done_irqs;
        send(1, 1, 1);
        send_after(WMIN + 1);
        chk("R3 dma_mode at gap 96", dma_mode, 1);
        chk("R3 frame_cnt 2", frame_cnt, 2);
        idle(WMAX + 10);
        chk("R7 one done irq on expiry", done_irqs - base_done, 1);
        chk("R3 no single irq in burst", rx_irqs - base_rx, 0);
        finish_cycle(2);

        // R3: upper window edge (gap 520).
        send(1, 1, 1);
        send_after(WMAX + 1);
        chk("R3 dma_mode at gap 520", dma_mode, 1);
        idle(WMAX + 10);
        finish_cycle(2);

        // R8/R6/R9: miss while busy, cap at 8, misses after close, saturation.
        base_done = done_irqs;
        send(1, 1, 1);
        send_after(150);
        force_busy = 1;
        send_after(150);
        chk("R8 miss while busy", miss_cnt, 1);
        chk("R8 frame_cnt unchanged by miss", frame_cnt, 2);
        chk("R8 evt_pending unchanged by miss", evt_pending, 2);
        force_busy = 0;
        for (int k = 0; k < 6; k++) send_after(150);
        idle(2);
        chk("R6 done irq at 8 frames", done_irqs - base_done, 1);
        chk("R6 frame_cnt capped", frame_cnt, 8);
        for (int k = 0; k < 8; k++) send_after(4);
        chk("R9 miss_cnt saturates", miss_cnt, MISS_MAX);
        chk("R8 frame_cnt unchanged after close", frame_cnt, 8);
        idle(10);
        finish_cycle(8);
        rd_miss();
        chk("R9 miss_cnt cleared by read", miss_cnt, 0);

        // R11: request and retire with the DMA model off.
        model_en = 0;
        send(1, 1, 1);
        send_after(120);
        chk("R11 dma_req with 2 waiting", dma_req, 1);
        @(negedge clk); force_busy = 1;
        @(negedge clk);
        chk("R11 dma_req low while busy", dma_req, 0);
        force_busy = 0;
        @(negedge clk);
        chk("R11 dma_req after one retire", dma_req, 1);
        @(negedge clk); force_busy = 1;
        @(negedge clk); force_busy = 0;
        @(negedge clk);
        chk("R11 dma_req low when queue empty", dma_req, 0);
        model_en = 1;
        idle(WMAX + 10);
        // R12: zero read with events pending does not exit.
        rd_cnt(); rd_cnt();
        idle(5);
        chk("R12 held while events pending", dma_mode, 1);
        ack(); ack();
        idle(1);
        chk("R12 exit after last ack", dma_mode, 0);

        // R13: timer frozen while tick is 0.
        base_rx = rx_irqs;
        send(1, 1, 1);
        tick = 0;
        idle(WMAX + 100);
        chk("R13 no release without ticks", rx_irqs - base_rx, 0);
        tick = 1;
        idle(WMAX + 10);
        chk("R13 release once ticks resume", rx_irqs - base_rx, 1);

        // Random bursts: first gap and length varied.
        for (int it = 0; it < 8; it++) begin
            int s1 = 60 + int'($urandom % 461);
            int len = 2 + int'($urandom % 9);
            rd_miss();
            base_rx = rx_irqs; base_done = done_irqs; base_miss = miss_cnt;
            send(1, 1, 1);
            send_after(s1);
            if (!in_win(s1 - 1)) begin
                idle(2);
                chk("R5 random short gap releases first", rx_irqs - base_rx, 1);
                chk("R5 random short gap no dma", dma_mode, 0);
                idle(WMAX + 10);
                chk("R4 random held frame released", rx_irqs - base_rx, 2);
                continue;
            end
            chk("R3 random burst entry", dma_mode, 1);
            for (int k = 3; k <= len; k++) send_after(WMIN + 1 + int'($urandom % 424));
            idle(WMAX + 10);
            chk("R6/R7 random single done irq", done_irqs - base_done, 1);
            chk("R8 random misses", miss_cnt, exp_miss(base_miss, len));
            finish_cycle(exp_taken(len));
            chk("R3 random no single irq", rx_irqs - base_rx, 0);
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule